// File: doc/BRIEF.md
# DMA Channel Burst Arbiter

This block decides which of several DMA channels may use a shared transfer engine. A channel takes part in arbitration when it raises its request, is enabled, and has its request unmasked. Channels are sorted into two groups. A channel in the high group always wins over any channel in the default group. Inside a group, the channel with the lowest index wins.

Once a channel holds the engine, it keeps it for a burst of 2^R completed transfers. R is a per-channel exponent. When the burst is used up, the channel stops requesting, or the channel loses its enable, the arbiter decides again on the following clock edge. If no channel is eligible, the grant goes to all zeros and `grant_valid_o` drops.

The grant works as a valid/ready pair towards the engine. `grant_valid_o` with `grant_o` is the offer. `xfer_done_i` is the engine's ready/acknowledge: one completed transfer for each cycle in which it is high while `grant_valid_o` is high. A strobe while `grant_valid_o` is low is ignored. The engine applies back-pressure by holding `xfer_done_i` low, and the grant then stays where it is for as long as needed. The grant and valid outputs are registered, so every decision appears one clock after the inputs that caused it.

Top module: `dma_burst_arbiter`

## Requirements
- R1: During reset and on the first cycle after it, `grant_o` is all zeros and `grant_valid_o` is low.
- R2: Channel c is eligible when `req_i[c]` is 1, `chan_en_i[c]` is 1 and `req_mask_i[c]` is 0. Only an eligible channel is ever granted.
- R3: When arbitration takes place, an eligible channel with `hi_pri_i[c]`=1 wins over every eligible channel with `hi_pri_i[c]`=0.
- R4: Among eligible channels of the same group, the lowest-numbered channel wins.
- R5: The exponent of channel c is `burst_exp_i[c*EXP_W +: EXP_W]`. While the granted channel stays eligible, it keeps the grant until 2^R `xfer_done_i` strobes have been counted. Arbitration takes place on the edge that counts the last strobe of the burst.
- R6: An exponent value above 10 is treated as 10, which gives a burst of 1024 transfers.
- R7: If the granted channel stops being eligible before its burst ends, the arbiter decides again on the next edge, without waiting for any strobe.
- R8: When no channel is eligible, `grant_o` becomes zero and `grant_valid_o` goes low one cycle later.
- R9: `grant_o` is one-hot exactly when `grant_valid_o` is high, and all zeros otherwise.
- R10: A `xfer_done_i` strobe while `grant_valid_o` is low, or in the cycle a new grant is issued, does not count toward any burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_CH | Per-channel request |
| chan_en_i | input | N_CH | Per-channel enable |
| req_mask_i | input | N_CH | Per-channel request mask, 1 blocks the request |
| hi_pri_i | input | N_CH | Per-channel group select, 1 = high group |
| burst_exp_i | input | N_CH*EXP_W | Per-channel burst exponent R, channel c at bits [c*EXP_W +: EXP_W] |
| xfer_done_i | input | 1 | One transfer completed (ready side of the grant) |
| grant_o | output | N_CH | One-hot grant to the engine |
| grant_valid_o | output | 1 | Grant is meaningful |

## Verification
The assertions assume that all inputs change only between clock edges and hold steady across each edge. They also assume that `xfer_done_i` means something only while `grant_valid_o` is high. The hold property relies on the engine not strobing `xfer_done_i` when it wants the grant kept. The bench drives every input on the falling edge. It raises the strobe only in bursts it intends to count, plus one deliberate run of strobes while idle. Its exponents include 0, small values and an out-of-range value.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned MAX_EXP = 10;
  localparam int unsigned CNT_W   = MAX_EXP + 1;
  typedef logic [CNT_W-1:0] burst_cnt_t;
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int unsigned N_CH = 4
) (
  input  logic [N_CH-1:0] elig_i,
  input  logic [N_CH-1:0] hi_i,
  output logic [N_CH-1:0] win_o,
  output logic            any_o
);
  logic [N_CH-1:0] hi_pool;
  logic [N_CH-1:0] pool;

  assign hi_pool = elig_i & hi_i;
  assign pool    = (|hi_pool) ? hi_pool : elig_i;
  assign any_o   = |elig_i;

  // lowest index of the chosen group wins
  always_comb begin
    win_o = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (pool[i]) begin
        win_o    = '0;
        win_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_arb_exp_sel.sv
module dma_arb_exp_sel
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned EXP_W = 4
) (
  input  logic [N_CH*EXP_W-1:0] exp_i,
  input  logic [N_CH-1:0]       sel_i,
  output burst_cnt_t            load_o
);
  logic [N_CH-1:0][EXP_W-1:0] masked;
  logic [EXP_W-1:0]           chosen;
  int unsigned                clamped;

  for (genvar c = 0; c < N_CH; c++) begin : g_mask
    assign masked[c] = sel_i[c] ? exp_i[c*EXP_W +: EXP_W] : '0;
  end

  always_comb begin
    chosen = '0;
    for (int c = 0; c < N_CH; c++) chosen |= masked[c];
    clamped = (int'(chosen) > int'(MAX_EXP)) ? MAX_EXP : int'(chosen);
    load_o  = burst_cnt_t'((1 << clamped) - 1);
  end
endmodule

// File: rtl/dma_arb_burst_cnt.sv
module dma_arb_burst_cnt
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  burst_cnt_t load_val_i,
  input  logic       dec_i,
  output logic       last_o
);
  burst_cnt_t left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      left_q <= '0;
    else if (load_i) left_q <= load_val_i;
    else if (dec_i)  left_q <= left_q - 1'b1;
  end

  assign last_o = (left_q == '0);
endmodule

// File: rtl/dma_burst_arbiter.sv
module dma_burst_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned EXP_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CH-1:0]       req_i,
  input  logic [N_CH-1:0]       chan_en_i,
  input  logic [N_CH-1:0]       req_mask_i,
  input  logic [N_CH-1:0]       hi_pri_i,
  input  logic [N_CH*EXP_W-1:0] burst_exp_i,
  input  logic                  xfer_done_i,
  output logic [N_CH-1:0]       grant_o,
  output logic                  grant_valid_o
);
  logic [N_CH-1:0] elig;
  logic [N_CH-1:0] winner;
  logic            any_elig;
  logic [N_CH-1:0] grant_q;
  logic            valid_q;
  logic            holder_live;
  logic            burst_last;
  logic            redecide;
  logic            count_dec;
  burst_cnt_t      load_val;

  assign elig = req_i & chan_en_i & ~req_mask_i;

  dma_arb_pick #(.N_CH(N_CH)) u_pick (
    .elig_i (elig),
    .hi_i   (hi_pri_i),
    .win_o  (winner),
    .any_o  (any_elig)
  );

  dma_arb_exp_sel #(.N_CH(N_CH), .EXP_W(EXP_W)) u_exp (
    .exp_i  (burst_exp_i),
    .sel_i  (winner),
    .load_o (load_val)
  );

  assign holder_live = valid_q && |(grant_q & elig);
  assign redecide    = !holder_live || (xfer_done_i && burst_last);
  assign count_dec   = holder_live && xfer_done_i && !burst_last;

  dma_arb_burst_cnt u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (redecide && any_elig),
    .load_val_i (load_val),
    .dec_i      (count_dec),
    .last_o     (burst_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      valid_q <= 1'b0;
    end else if (redecide) begin
      grant_q <= winner;
      valid_q <= any_elig;
    end
  end

  assign grant_o       = grant_q;
  assign grant_valid_o = valid_q;
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned EXP_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_CH-1:0]       req_i,
  input logic [N_CH-1:0]       chan_en_i,
  input logic [N_CH-1:0]       req_mask_i,
  input logic                  xfer_done_i,
  input logic [N_CH-1:0]       grant_o,
  input logic                  grant_valid_o
);
  logic [N_CH-1:0] ok;
  assign ok = req_i & chan_en_i & ~req_mask_i;

  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> $countones(grant_o) == 1);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid_o |-> grant_o == '0);

  assert_new_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && !$stable(grant_o)) |-> |($past(ok) & grant_o));

  assert_hold_without_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && |(grant_o & ok) && !xfer_done_i) |=> ($stable(grant_o) && grant_valid_o));

  assert_no_eligible_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ok == '0) |=> !grant_valid_o);
endmodule

bind dma_burst_arbiter dma_arb_checker #(.N_CH(N_CH), .EXP_W(EXP_W)) u_arb_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_i         (req_i),
  .chan_en_i     (chan_en_i),
  .req_mask_i    (req_mask_i),
  .xfer_done_i   (xfer_done_i),
  .grant_o       (grant_o),
  .grant_valid_o (grant_valid_o)
);

// File: tb/test_dma_burst_arbiter.sv
module test_dma_burst_arbiter;
  localparam int N  = 4;
  localparam int EW = 4;

  typedef struct {
    logic [N-1:0] grant;
    logic         valid;
    string        tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, en = '1, mask = '0, hi = '0;
  logic [N*EW-1:0] exps = '0;
  logic          done = 1'b0;
  logic [N-1:0]  grant;
  logic          gvalid;

  int checks = 0, errors = 0, cycles = 0;
  exp_t q[$];
  bit   m_valid = 0;
  int   m_idx = 0;
  int   m_left = 0;

  always #2.5 clk = ~clk;

  dma_burst_arbiter #(.N_CH(N), .EXP_W(EW)) i_dma_burst_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .chan_en_i(en), .req_mask_i(mask),
    .hi_pri_i(hi), .burst_exp_i(exps), .xfer_done_i(done),
    .grant_o(grant), .grant_valid_o(gvalid)
  );

  function automatic int pick(input logic [N-1:0] el);
    for (int i = 0; i < N; i++) if (el[i] && hi[i]) return i;
    for (int i = 0; i < N; i++) if (el[i]) return i;
    return -1;
  endfunction

  // driver: inputs already set at a falling edge; predict, push, advance
  task automatic step(input string tag);
    logic [N-1:0] el;
    bit live;
    int w, r;
    exp_t e;
    el = req & en & ~mask;
    live = m_valid && el[m_idx];
    if (!live || (done && m_left == 0)) begin
      w = pick(el);
      m_valid = (w >= 0);
      if (w >= 0) begin
        m_idx = w;
        r = int'(exps[w*EW +: EW]);
        if (r > 10) r = 10;
        m_left = (1 << r) - 1;
      end
    end else if (done) begin
      m_left--;
    end
    e.grant = m_valid ? (N)'(1 << m_idx) : '0;
    e.valid = m_valid;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (grant !== e.grant || gvalid !== e.valid) begin
          errors++;
          $display("FAIL %s grant=%b valid=%b expected grant=%b valid=%b",
                   e.tag, grant, gvalid, e.grant, e.valid);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic set_exp(input int ch, input int v);
    exps[ch*EW +: EW] = EW'(v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (grant !== '0 || gvalid !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset grant=%b valid=%b expected 0000/0", grant, gvalid);
    end
    rst_n = 1'b1;
    step("R1 after reset");

    // R4: lowest index in default group
    req = 4'b1010; step("R4 lowest index");
    req = 4'b0000; step("R8 idle");
    step("R8 idle hold");

    // R3: high group beats lower index
    hi = 4'b1000; req = 4'b1001; step("R3 high group wins");
    req = 4'b0000; step("R8 idle");
    hi = 4'b1100; req = 4'b1101; step("R3 R4 lowest in high group");
    req = 4'b0000; hi = '0; step("R8 idle");

    // R2: disabled and masked channels are skipped
    en = 4'b1110; mask = 4'b0010; req = 4'b0111; step("R2 skip disabled and masked");
    req = 4'b0011; step("R2 R8 none eligible");
    en = '1; mask = '0; req = 4'b0000; step("R8 idle");

    // R5: burst of 4 then lower index takes over
    set_exp(2, 2); set_exp(0, 0);
    req = 4'b0100; step("R5 grant ch2");
    req = 4'b0101;
    step("R5 hold no strobe");
    done = 1'b1;
    for (int k = 0; k < 4; k++) step("R5 burst of 4");
    done = 1'b0;
    step("R5 ch0 after burst");
    // R5 with R=0: every strobe redecides
    done = 1'b1; req = 4'b0101; step("R5 R=0 single");
    done = 1'b0; req = 4'b0000; step("R8 idle");

    // R7: early drop
    set_exp(2, 3);
    req = 4'b1100; step("R7 grant ch2");
    done = 1'b1; step("R7 one strobe");
    done = 1'b0; req = 4'b1000; step("R7 early redecide");
    req = 4'b0000; step("R8 idle");

    // R10: strobes while idle are ignored
    set_exp(1, 1);
    done = 1'b1; step("R10 strobe idle"); step("R10 strobe idle");
    req = 4'b0010; step("R10 grant with strobe");
    done = 1'b0; req = 4'b0011; step("R10 hold");
    done = 1'b1; step("R10 first counted"); step("R10 second counted");
    done = 1'b0; step("R10 switch to ch0");
    req = 4'b0000; step("R8 idle");

    // R6: exponent 15 acts as 10
    set_exp(1, 15);
    req = 4'b0010; step("R6 grant ch1");
    req = 4'b0011; done = 1'b1;
    for (int k = 0; k < 1024; k++) step("R6 clamped burst");
    done = 1'b0; step("R6 ch0 after 1024");
    req = 4'b0000; step("R8 idle");

    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule